// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Port

This block is a synchronous serial port with independent transmit and receive halves. Software reaches it through a plain register write/read port. Each half owns a control register (enable, clock source, word length), a clock divisor, a data register seen by software, and a hidden shift register. Data moves over a bit clock, a data line and a frame-sync line. A frame-sync pulse lasting one bit clock marks the slot just before the most significant bit of each word.

The transmit half takes each word from its holding register into its shift register at the frame-sync slot. At that moment it raises its interrupt, so software can write the next word while the current one is still shifting out. Back-to-back words leave no idle bit clock between them. The receive half collects bits and copies each finished word into its data register, raising its interrupt.

After its enable bit is set, a half ignores its first three bit-clock rising edges. Clearing the enable bit aborts the word in flight and clears that half's status, while the control and divisor registers keep their values. The bit clock comes either from an internal divider or from an external input, and selecting the external input stops the block driving its clock pin. The register port has no back-pressure: every write and read completes in the cycle it is presented.

Top module: `dbuf_serial_port`

## Requirements
- R1: After reset, every readable register (addresses 0 to 6) reads zero, both interrupts and tx_fs, tx_d, tx_sclk_out are low, and tx_sclk_oe is high.
- R2: At the bit-clock rising edge where a held word enters the shift register, tx_fs goes high and tx_irq goes high in the same clock cycle.
- R3: A word of N bits occupies N+1 bit clocks. The first is the frame-sync slot, with tx_fs high and tx_d low. Then come N bits, most significant first, each launched on a rising bit-clock edge. If the next word was written in time, its frame-sync slot follows the last bit with no gap.
- R4: With the internal clock selected, tx_sclk_out has a period of 2*(divisor+1) system clocks and tx_sclk_oe is high.
- R5: After the enable bit is set, the first three rising bit-clock edges do nothing. With a word already written, tx_fs rises on the fourth rising edge.
- R6: If a word finishes while the holding register is empty, STATUS bit 0 (transmit underflow) is set and stays set while enabled, and tx_d is held low.
- R7: When a full word has been received it appears in RX_DATA (address 5) and rx_irq goes high. A read of address 5 clears rx_irq.
- R8: If a word completes while rx_irq is still high, STATUS bit 1 (receive overflow) is set and RX_DATA holds the newer word.
- R9: A write to TX_DATA (address 4) clears tx_irq on the next clock.
- R10: Clearing a half's enable bit (control bit 0) aborts its word in flight and clears its status and interrupt. The control register reads back unchanged apart from bit 0, and the half resumes normally once enabled again.
- R11: With control bit 1 set (external clock), the half's clock output enable is low and its clock output stays low.
- R12: Control bits [7:4] hold the word length minus one, which selects 3 to 16 bits. Field values 0 and 1 give 3 bits, and the lowest bits of a written word are the ones sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, clears all registers |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 TX_CTL, 1 RX_CTL, 2 TX_DIV, 3 RX_DIV, 4 TX_DATA |
| wr_data | input | MAXW | Write data |
| rd_en | input | 1 | Register read strobe (a read of address 5 clears rx_irq) |
| rd_addr | input | 3 | Read address: 0 to 3 as for writes, 5 RX_DATA, 6 STATUS |
| rd_data | output | MAXW | Read data, combinational from rd_addr |
| tx_sclk_in | input | 1 | External transmit bit clock |
| tx_sclk_out | output | 1 | Internally generated transmit bit clock |
| tx_sclk_oe | output | 1 | High while tx_sclk_out is driven |
| tx_fs | output | 1 | Transmit frame sync |
| tx_d | output | 1 | Transmit serial data |
| tx_irq | output | 1 | Transmit holding register free |
| rx_sclk_in | input | 1 | External receive bit clock |
| rx_sclk_out | output | 1 | Internally generated receive bit clock |
| rx_sclk_oe | output | 1 | High while rx_sclk_out is driven |
| rx_fs | input | 1 | Receive frame sync, sampled on falling bit-clock edges |
| rx_d | input | 1 | Receive serial data, sampled on falling bit-clock edges |
| rx_irq | output | 1 | Receive word available |

STATUS (address 6): bit 0 transmit underflow, bit 1 receive overflow, bit 2 tx_irq, bit 3 rx_irq.

## Verification
The hardest states to reach are the receive overflow and an abort in the middle of a word. Both depend on where the transmitter sits inside its frame, measured in bit clocks. The bench loops the transmit pins back into the receive half, which runs on the external clock. It paces its register accesses by the interrupt lines: it leaves RX_DATA unread across two streamed words to force the overwrite. It clears the transmit enable a fixed number of system clocks after a load, so the disable lands between bits. A behavioural model of the transmit pins is compared on every clock, so a slip of one bit clock in the start-up delay, the frame slot or the handoff shows up at once.

// File: rtl/dbsp_pkg.sv
package dbsp_pkg;
  localparam logic [2:0] A_TXCTL = 3'd0;
  localparam logic [2:0] A_RXCTL = 3'd1;
  localparam logic [2:0] A_TXDIV = 3'd2;
  localparam logic [2:0] A_RXDIV = 3'd3;
  localparam logic [2:0] A_TXDAT = 3'd4;
  localparam logic [2:0] A_RXDAT = 3'd5;
  localparam logic [2:0] A_STAT  = 3'd6;

  // length field -> bits per word; fields below 2 give the 3-bit minimum
  function automatic int unsigned fld2bits(input int unsigned f);
    return (f < 2) ? 3 : f + 1;
  endfunction
endpackage

// File: rtl/dbsp_sclk_gen.sv
module dbsp_sclk_gen #(
  parameter int DIVW    = 8,
  parameter int STARTUP = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            ext_sel,
  input  logic [DIVW-1:0] div,
  input  logic            sclk_in,
  output logic            sclk_out,
  output logic            sclk_oe,
  output logic            go_rise,
  output logic            go_fall
);
  localparam int STW = $clog2(STARTUP + 1);

  logic [DIVW-1:0] cnt;
  logic            lvl;
  logic [2:0]      sync;
  logic [STW-1:0]  st;
  logic            int_run, tick, rise, fall, ready;

  assign int_run = run & ~ext_sel;
  assign tick    = int_run && (cnt == div);

  always_comb begin
    if (ext_sel) begin
      rise = run & sync[1] & ~sync[2];
      fall = run & ~sync[1] & sync[2];
    end else begin
      rise = tick & ~lvl;
      fall = tick & lvl;
    end
  end

  assign ready   = (st == STW'(STARTUP));
  assign go_rise = rise & ready;
  assign go_fall = fall & ready;
  assign sclk_out = lvl;
  assign sclk_oe  = ~ext_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      lvl  <= 1'b0;
      sync <= '0;
      st   <= '0;
    end else begin
      sync <= {sync[1:0], sclk_in};
      if (!int_run) begin
        cnt <= '0;
        lvl <= 1'b0;
      end else if (tick) begin
        cnt <= '0;
        lvl <= ~lvl;
      end else begin
        cnt <= cnt + 1'b1;
      end
      if (!run)
        st <= '0;
      else if (rise && !ready)
        st <= st + 1'b1;
    end
  end
endmodule

// File: rtl/dbsp_tx.sv
module dbsp_tx #(
  parameter int MAXW = 16,
  parameter int CNTW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [CNTW-1:0] nbits,
  input  logic            go_rise,
  input  logic            wr,
  input  logic [MAXW-1:0] wdata,
  output logic            tx_d,
  output logic            tx_fs,
  output logic            irq,
  output logic            unf,
  output logic            load
);
  logic [MAXW-1:0] hold, shreg;
  logic            hold_full, busy, shifting;
  logic [CNTW-1:0] left;

  assign shifting = busy && (left != '0);
  assign load     = en & go_rise & ~shifting & hold_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0; shreg <= '0; hold_full <= 1'b0; busy <= 1'b0;
      left <= '0; tx_d <= 1'b0; tx_fs <= 1'b0; irq <= 1'b0; unf <= 1'b0;
    end else if (!en) begin
      hold_full <= 1'b0; busy <= 1'b0; left <= '0;
      tx_d <= 1'b0; tx_fs <= 1'b0; irq <= 1'b0; unf <= 1'b0;
    end else begin
      if (wr) begin
        hold      <= wdata;
        hold_full <= 1'b1;
      end else if (load) begin
        hold_full <= 1'b0;
      end
      if (load)
        irq <= 1'b1;
      else if (wr)
        irq <= 1'b0;
      if (go_rise) begin
        if (shifting) begin
          tx_d  <= shreg[MAXW-1];
          shreg <= shreg << 1;
          left  <= left - 1'b1;
          tx_fs <= 1'b0;
        end else if (hold_full) begin
          shreg <= hold << (CNTW'(MAXW) - nbits);
          left  <= nbits;
          busy  <= 1'b1;
          tx_fs <= 1'b1;
          tx_d  <= 1'b0;
        end else begin
          if (busy) unf <= 1'b1;
          busy  <= 1'b0;
          tx_d  <= 1'b0;
          tx_fs <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dbsp_rx.sv
module dbsp_rx #(
  parameter int MAXW = 16,
  parameter int CNTW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [CNTW-1:0] nbits,
  input  logic            go_fall,
  input  logic            rx_d,
  input  logic            rx_fs,
  input  logic            rd_clr,
  output logic [MAXW-1:0] data,
  output logic            irq,
  output logic            ovf,
  output logic            done
);
  logic [MAXW-1:0] shreg;
  logic            busy;
  logic [CNTW-1:0] left;

  assign done = en & go_fall & busy & (left == CNTW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0; shreg <= '0; busy <= 1'b0; left <= '0;
      irq <= 1'b0; ovf <= 1'b0;
    end else if (!en) begin
      shreg <= '0; busy <= 1'b0; left <= '0; irq <= 1'b0; ovf <= 1'b0;
    end else begin
      if (go_fall) begin
        if (!busy) begin
          if (rx_fs) begin
            busy  <= 1'b1;
            left  <= nbits;
            shreg <= '0;
          end
        end else begin
          shreg <= {shreg[MAXW-2:0], rx_d};
          left  <= left - 1'b1;
          if (left == CNTW'(1)) begin
            busy <= 1'b0;
            data <= {shreg[MAXW-2:0], rx_d};
          end
        end
      end
      if (done) begin
        irq <= 1'b1;
        if (irq) ovf <= 1'b1;
      end else if (rd_clr) begin
        irq <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dbuf_serial_port.sv
module dbuf_serial_port
  import dbsp_pkg::*;
#(
  parameter int MAXW    = 16,
  parameter int DIVW    = 8,
  parameter int STARTUP = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      wr_addr,
  input  logic [MAXW-1:0] wr_data,
  input  logic            rd_en,
  input  logic [2:0]      rd_addr,
  output logic [MAXW-1:0] rd_data,
  input  logic            tx_sclk_in,
  output logic            tx_sclk_out,
  output logic            tx_sclk_oe,
  output logic            tx_fs,
  output logic            tx_d,
  output logic            tx_irq,
  input  logic            rx_sclk_in,
  output logic            rx_sclk_out,
  output logic            rx_sclk_oe,
  input  logic            rx_fs,
  input  logic            rx_d,
  output logic            rx_irq
);
  localparam int LENW = $clog2(MAXW);
  localparam int CNTW = $clog2(MAXW + 1);

  logic            tx_en, tx_ext, rx_en, rx_ext;
  logic [LENW-1:0] tx_lenf, rx_lenf;
  logic [DIVW-1:0] tx_div, rx_div;
  logic [CNTW-1:0] tx_nbits, rx_nbits;
  logic            tx_rise, tx_fall_unused, rx_rise_unused, rx_fall;
  logic            tx_load, tx_unf, rx_ovf, rx_done, rx_clr, tx_wr;
  logic [MAXW-1:0] rx_word;

  // control and divisor registers: only reset clears them
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en <= 1'b0; tx_ext <= 1'b0; tx_lenf <= '0;
      rx_en <= 1'b0; rx_ext <= 1'b0; rx_lenf <= '0;
      tx_div <= '0; rx_div <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_TXCTL: begin
          tx_en <= wr_data[0]; tx_ext <= wr_data[1]; tx_lenf <= wr_data[4 +: LENW];
        end
        A_RXCTL: begin
          rx_en <= wr_data[0]; rx_ext <= wr_data[1]; rx_lenf <= wr_data[4 +: LENW];
        end
        A_TXDIV: tx_div <= wr_data[DIVW-1:0];
        A_RXDIV: rx_div <= wr_data[DIVW-1:0];
        default: ;
      endcase
    end
  end

  assign tx_nbits = CNTW'(fld2bits(32'(tx_lenf)));
  assign rx_nbits = CNTW'(fld2bits(32'(rx_lenf)));
  assign tx_wr    = wr_en && (wr_addr == A_TXDAT);
  assign rx_clr   = rd_en && (rd_addr == A_RXDAT);

  always_comb begin
    case (rd_addr)
      A_TXCTL: rd_data = MAXW'({tx_lenf, 2'b00, tx_ext, tx_en});
      A_RXCTL: rd_data = MAXW'({rx_lenf, 2'b00, rx_ext, rx_en});
      A_TXDIV: rd_data = MAXW'(tx_div);
      A_RXDIV: rd_data = MAXW'(rx_div);
      A_RXDAT: rd_data = rx_word;
      A_STAT:  rd_data = MAXW'({rx_irq, tx_irq, rx_ovf, tx_unf});
      default: rd_data = '0;
    endcase
  end

  dbsp_sclk_gen #(.DIVW(DIVW), .STARTUP(STARTUP)) u_tx_clk (
    .clk(clk), .rst_n(rst_n), .run(tx_en), .ext_sel(tx_ext), .div(tx_div),
    .sclk_in(tx_sclk_in), .sclk_out(tx_sclk_out), .sclk_oe(tx_sclk_oe),
    .go_rise(tx_rise), .go_fall(tx_fall_unused)
  );

  dbsp_sclk_gen #(.DIVW(DIVW), .STARTUP(STARTUP)) u_rx_clk (
    .clk(clk), .rst_n(rst_n), .run(rx_en), .ext_sel(rx_ext), .div(rx_div),
    .sclk_in(rx_sclk_in), .sclk_out(rx_sclk_out), .sclk_oe(rx_sclk_oe),
    .go_rise(rx_rise_unused), .go_fall(rx_fall)
  );

  dbsp_tx #(.MAXW(MAXW), .CNTW(CNTW)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .nbits(tx_nbits), .go_rise(tx_rise),
    .wr(tx_wr), .wdata(wr_data), .tx_d(tx_d), .tx_fs(tx_fs), .irq(tx_irq),
    .unf(tx_unf), .load(tx_load)
  );

  dbsp_rx #(.MAXW(MAXW), .CNTW(CNTW)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .nbits(rx_nbits), .go_fall(rx_fall),
    .rx_d(rx_d), .rx_fs(rx_fs), .rd_clr(rx_clr), .data(rx_word), .irq(rx_irq),
    .ovf(rx_ovf), .done(rx_done)
  );
endmodule

// File: rtl/dbsp_chk.sv
module dbsp_chk
  import dbsp_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tx_en,
  input logic       tx_fs,
  input logic       tx_d,
  input logic       tx_irq,
  input logic       tx_load,
  input logic       tx_unf,
  input logic       tx_sclk_oe,
  input logic       tx_sclk_out,
  input logic       rx_irq,
  input logic       rx_done,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic       rd_en,
  input logic [2:0] rd_addr
);
  AST_LOAD_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> (tx_irq && tx_fs)); // R2

  AST_FS_SLOT_DATA_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fs |-> !tx_d); // R3

  AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && $past(tx_en) && $past(tx_unf)) |-> tx_unf); // R6

  AST_RX_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == A_RXDAT && !rx_done) |=> !rx_irq); // R7

  AST_TX_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_TXDAT && !tx_load) |=> !tx_irq); // R9

  AST_DISABLE_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en) |=> (!tx_irq && !tx_fs && !tx_d && !tx_unf)); // R10

  AST_EXT_CLOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_sclk_oe |-> !tx_sclk_out); // R11
endmodule

bind dbuf_serial_port dbsp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_fs(tx_fs), .tx_d(tx_d),
  .tx_irq(tx_irq), .tx_load(tx_load), .tx_unf(tx_unf), .tx_sclk_oe(tx_sclk_oe),
  .tx_sclk_out(tx_sclk_out), .rx_irq(rx_irq), .rx_done(rx_done),
  .wr_en(wr_en), .wr_addr(wr_addr), .rd_en(rd_en), .rd_addr(rd_addr)
);

// File: tb/dbuf_serial_port_tb.sv
module dbuf_serial_port_tb;
  localparam int MAXW = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]      wr_addr = '0, rd_addr = '0;
  logic [MAXW-1:0] wr_data = '0;
  logic [MAXW-1:0] rd_data;
  logic            tx_sclk_in = 1'b0;
  logic            tx_sclk_out, tx_sclk_oe, tx_fs, tx_d, tx_irq;
  logic            rx_sclk_out, rx_sclk_oe, rx_irq;

  always #5 clk = ~clk;

  dbuf_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .tx_sclk_in(tx_sclk_in), .tx_sclk_out(tx_sclk_out), .tx_sclk_oe(tx_sclk_oe),
    .tx_fs(tx_fs), .tx_d(tx_d), .tx_irq(tx_irq),
    .rx_sclk_in(tx_sclk_out), .rx_sclk_out(rx_sclk_out), .rx_sclk_oe(rx_sclk_oe),
    .rx_fs(tx_fs), .rx_d(tx_d), .rx_irq(rx_irq)
  );

  int n_cmp = 0, n_bad = 0;
  bit mdl_on = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int nb(input int f);
    return (f < 2) ? 3 : f + 1;
  endfunction

  // behavioural reference for the transmit pins
  bit m_en, m_ext, m_lvl, m_hf, m_busy, m_d, m_fs, m_irq, m_unf;
  int m_lenf, m_div, m_cnt, m_st, m_bits;
  logic [15:0] m_hold, m_cur;

  always @(posedge clk) begin : model
    bit rise, go, load;
    if (!rst_n) begin
      m_en = 0; m_ext = 0; m_lenf = 0; m_div = 0; m_cnt = 0; m_lvl = 0; m_st = 0;
      m_hf = 0; m_busy = 0; m_bits = 0; m_d = 0; m_fs = 0; m_irq = 0; m_unf = 0;
      m_hold = 0; m_cur = 0;
    end else begin
      if (!m_en) begin
        m_cnt = 0; m_lvl = 0; m_st = 0; m_hf = 0; m_busy = 0; m_bits = 0;
        m_d = 0; m_fs = 0; m_irq = 0; m_unf = 0;
      end else begin
        rise = 0;
        if (m_ext) begin
          m_cnt = 0; m_lvl = 0;
        end else begin
          rise = (m_cnt == m_div) && !m_lvl;
          if (m_cnt == m_div) begin m_cnt = 0; m_lvl = !m_lvl; end
          else m_cnt++;
        end
        go = rise && (m_st == 3);
        if (rise && m_st < 3) m_st++;
        load = 0;
        if (go) begin
          if (m_busy && m_bits > 0) begin
            m_d = m_cur[m_bits-1]; m_bits--; m_fs = 0;
          end else if (m_hf) begin
            m_cur = m_hold; m_bits = nb(m_lenf); m_busy = 1; m_fs = 1; m_d = 0; load = 1;
          end else begin
            if (m_busy) m_unf = 1;
            m_busy = 0; m_d = 0; m_fs = 0;
          end
        end
        if (wr_en && wr_addr == 3'd4) begin m_hold = wr_data; m_hf = 1; end
        else if (load) m_hf = 0;
        if (load) m_irq = 1;
        else if (wr_en && wr_addr == 3'd4) m_irq = 0;
      end
      if (wr_en && wr_addr == 3'd0) begin
        m_en = wr_data[0]; m_ext = wr_data[1]; m_lenf = int'(wr_data[7:4]);
      end
      if (wr_en && wr_addr == 3'd2) m_div = int'(wr_data[7:0]);
    end
  end

  always @(negedge clk) begin
    if (mdl_on && rst_n) begin
      chk("R3 tx_d vs model", 32'(tx_d), 32'(m_d));
      chk("R3 tx_fs vs model", 32'(tx_fs), 32'(m_fs));
      chk("R4 tx_sclk_out vs model", 32'(tx_sclk_out), 32'(m_lvl));
      chk("R2 tx_irq vs model", 32'(tx_irq), 32'(m_irq));
    end
  end

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary_and_end();
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_tx_irq();
    while (tx_irq !== 1'b1) @(negedge clk);
  endtask

  task automatic wait_rx_irq();
    while (rx_irq !== 1'b1) @(negedge clk);
  endtask

  initial begin : main
    logic [15:0] v;
    int cnt_r, per;
    logic prev;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    mdl_on = 1'b1;

    // R1: reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      chk("R1 register reset value", 32'(v), 32'h0);
    end
    chk("R1 tx_sclk_oe after reset", 32'(tx_sclk_oe), 32'h1);
    chk("R1 irqs after reset", 32'({tx_irq, rx_irq, tx_fs, tx_d}), 32'h0);

    // 8-bit words, divisor 3, receiver on the external clock
    wr(3'd2, 16'd3);
    wr(3'd1, 16'h0073);
    wr(3'd0, 16'h0071);
    wr(3'd4, 16'h00A6);
    // R5: frame sync on the fourth rising edge
    prev = tx_sclk_out; cnt_r = 0;
    while (tx_fs !== 1'b1) begin
      @(negedge clk);
      if (tx_sclk_out && !prev) cnt_r++;
      prev = tx_sclk_out;
    end
    chk("R5 rising edges before first frame sync", 32'(cnt_r), 32'd4);
    chk("R2 tx_irq at handoff", 32'(tx_irq), 32'h1);
    chk("R4 tx_sclk_oe internal", 32'(tx_sclk_oe), 32'h1);
    // R4: bit clock period
    prev = 1'b1; per = 0;
    forever begin
      @(negedge clk); per++;
      if (tx_sclk_out && !prev) break;
      prev = tx_sclk_out;
    end
    chk("R4 bit clock period", 32'(per), 32'd8);
    wr(3'd4, 16'h005B);
    chk("R9 tx_irq cleared by write", 32'(tx_irq), 32'h0);
    wait_rx_irq();
    rd(3'd5, v);
    chk("R7 first received word", 32'(v), 32'h00A6);
    chk("R7 rx_irq cleared by read", 32'(rx_irq), 32'h0);
    wait_tx_irq();
    wait_rx_irq();
    rd(3'd5, v);
    chk("R7 second received word", 32'(v), 32'h005B);
    repeat (40) @(negedge clk);
    rd(3'd6, v);
    chk("R6 underflow status bit", 32'(v[0]), 32'h1);
    chk("R6 data held low", 32'(tx_d), 32'h0);

    // R12: 3-bit words from a zero field, divisor 5
    wr(3'd1, 16'h0072);
    wr(3'd0, 16'h0070);
    wr(3'd2, 16'd5);
    wr(3'd1, 16'h0003);
    wr(3'd0, 16'h0001);
    wr(3'd4, 16'hFFF5);
    wait_rx_irq();
    rd(3'd5, v);
    chk("R12 three-bit word", 32'(v), 32'h5);

    // R12: 16-bit words
    wr(3'd1, 16'h00F2);
    wr(3'd0, 16'h00F0);
    wr(3'd1, 16'h00F3);
    wr(3'd0, 16'h00F1);
    wr(3'd4, 16'hA5C3);
    wait_rx_irq();
    rd(3'd5, v);
    chk("R12 sixteen-bit word", 32'(v), 32'hA5C3);

    // R3/R8: stream three words back to back without reading
    wr(3'd1, 16'h00F2);
    wr(3'd0, 16'h00F0);
    wr(3'd1, 16'h00F3);
    wr(3'd0, 16'h00F1);
    wr(3'd4, 16'h1234);
    wait_tx_irq();
    wr(3'd4, 16'hBEEF);
    wait_tx_irq();
    wr(3'd4, 16'h0F0F);
    wait_tx_irq();
    repeat (10) @(negedge clk);
    rd(3'd6, v);
    chk("R8 overflow status bit", 32'(v[1]), 32'h1);
    chk("R3 no underflow in stream", 32'(v[0]), 32'h0);
    rd(3'd5, v);
    chk("R8 data overwritten by newer word", 32'(v), 32'hBEEF);
    wait_rx_irq();
    rd(3'd5, v);
    chk("R3 third streamed word", 32'(v), 32'h0F0F);

    // R10: abort mid-word after an underflow
    repeat (60) @(negedge clk);
    rd(3'd6, v);
    chk("R6 underflow after stream", 32'(v[0]), 32'h1);
    wr(3'd4, 16'h7E81);
    wait_tx_irq();
    repeat (30) @(negedge clk);
    wr(3'd0, 16'h00F0);
    @(negedge clk);
    chk("R10 pins idle after abort", 32'({tx_d, tx_fs, tx_irq, tx_sclk_out}), 32'h0);
    rd(3'd0, v);
    chk("R10 control kept", 32'(v), 32'h00F0);
    rd(3'd6, v);
    chk("R10 transmit status cleared", 32'(v[0]), 32'h0);
    wr(3'd1, 16'h00F2);
    @(negedge clk);
    rd(3'd6, v);
    chk("R10 all status cleared", 32'(v), 32'h0);
    rd(3'd1, v);
    chk("R10 receive control kept", 32'(v), 32'h00F2);
    wr(3'd1, 16'h00F3);
    wr(3'd0, 16'h00F1);
    wr(3'd4, 16'hC001);
    wait_rx_irq();
    rd(3'd5, v);
    chk("R10 word after re-enable", 32'(v), 32'hC001);

    // R11: external clock selected
    wr(3'd1, 16'h00F2);
    wr(3'd0, 16'h00F0);
    wr(3'd0, 16'h00F3);
    per = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (tx_sclk_oe !== 1'b0 || tx_sclk_out !== 1'b0) per++;
    end
    chk("R11 transmit clock not driven", 32'(per), 32'd0);
    chk("R11 receive clock oe low", 32'(rx_sclk_oe), 32'h0);
    wr(3'd0, 16'h00F0);
    repeat (5) @(negedge clk);
    summary_and_end();
  end
endmodule